// File: doc/BRIEF.md
# Sampling Converter Serial Result Transmitter

This block is the digital half of a 12-bit sampling converter. A rising edge on an asynchronous convert-start pin puts the sampler into hold and starts a conversion. While the conversion runs, the block shifts the result out as a framed 16-bit serial word. The word goes out on a generated serial clock, together with an active-low frame strobe and a data line. The result itself arrives on a parallel port from a behavioural converter model. The block captures that port at the moment the start is accepted.

The serial clock comes from the system clock through a divider of `CLK_DIV` cycles. A conversion lasts a fixed number of rising serial-clock edges. That count grows by one when the start is accepted in the same cycle that the clock is about to rise, because that edge cannot be used.

A mode pin chooses between two behaviours of the serial clock. In one it runs continuously. In the other it is parked between words and its output enable is dropped once the word has been sent. Parking the clock also makes the conversion length fixed. A one-cycle done pulse closes each conversion.

Top module: `conv_serial_tx`

## Requirements
- R1: After reset, and until the first start is accepted: `frame_n_o`=1, `sdat_o`=0, `hold_o`=0, `done_o`=0 and `sclk_o`=0. With `free_run`=0, `sclk_oe_o`=0.
- R2: `cnv_start_in` passes through two synchronizer flops and an edge detector. `hold_o` first reads 1 three clock edges after the edge at which `cnv_start_in` is first seen high.
- R3: With `free_run`=1 and the start accepted away from a rising serial-clock edge, `sclk_o` rises 19 times from the start up to and including the cycle in which `done_o` is high.
- R4: With `free_run`=1 and the start accepted in the cycle just before a rising edge of `sclk_o`, that edge cannot be used, and the count from R3 becomes 20.
- R5: With `free_run`=0 the serial clock is parked low between conversions, and every conversion spans exactly 19 rising edges.
- R6: The serial word is 16 bits, most significant bit first: four zeros, then the 12-bit two's-complement result unchanged. Each bit is read on a falling edge of `sclk_o` while `frame_n_o`=0, and the first such falling edge carries the first zero.
- R7: `frame_n_o` goes low on the first usable rising edge and high again on the 17th. It stays high between words.
- R8: With `free_run`=0, `sclk_oe_o` is 1 only while `frame_n_o`=0. With `free_run`=1, `sclk_oe_o` is always 1.
- R9: `done_o` is a single-cycle pulse on the 19th usable rising edge. In that same cycle `hold_o` reads 0 and `frame_n_o` reads 1.
- R10: A convert-start edge that arrives while a conversion is running is ignored. After the single done pulse, no new frame and no hold follow.
- R11: With `free_run`=1, `sclk_o` has a period of `CLK_DIV` (default 8) clock cycles, high for the first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial clock is derived from it |
| rst | input | 1 | Synchronous active-high reset |
| cnv_start_in | input | 1 | Asynchronous convert-start; a rising edge starts a conversion |
| free_run | input | 1 | 1: serial clock runs continuously; 0: serial clock is parked between words |
| res_in | input | RES_W | Two's-complement result from the converter model |
| sclk_o | output | 1 | Generated serial clock level |
| sclk_oe_o | output | 1 | Output enable of the serial clock; 0 means high impedance |
| frame_n_o | output | 1 | Active-low frame strobe marking the serial word |
| sdat_o | output | 1 | Serial data; changes on rising `sclk_o` |
| hold_o | output | 1 | Sampler held for the whole conversion |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The accepted start and a rising serial-clock edge can fall in the same cycle, and that coincidence decides whether the conversion spans 19 or 20 edges. The bench watches `sclk_o` for a rise and then raises the start either at once or five cycles later. With the default divider, the second choice puts acceptance exactly one cycle before the next rise. The test then counts the observed rises up to the done pulse and compares the count with 20 or 19. The word read on falling edges must still come out intact.

// File: rtl/cst_pkg.sv
package cst_pkg;

  // Progress of one conversion inside the frame controller
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // waiting for an accepted start
    PH_SYNC  = 2'd1,  // held, waiting for the first usable rising edge
    PH_WORD  = 2'd2,  // frame low, bits being shifted
    PH_TAIL  = 2'd3   // frame high again, finishing the conversion
  } phase_e;

endpackage

// File: rtl/cst_start_sync.sv
module cst_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);

  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);

endmodule

// File: rtl/cst_sclk_gen.sv
module cst_sclk_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic park,
  output logic tick_o,
  output logic sclk_o
);

  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] PARK = CW'(DIV - 2);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    if (park)              cnt_nxt = PARK;
    else if (cnt == LAST)  cnt_nxt = '0;
    else                   cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= PARK;
      sclk_o <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      sclk_o <= (cnt_nxt < HALF);
    end
  end

  // the serial clock rises on the next edge exactly when this is high
  assign tick_o = (cnt == LAST);

  // R11
  rise_after_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> $past(tick_o));

endmodule

// File: rtl/cst_frame_ctrl.sv
module cst_frame_ctrl #(
  parameter int RES_W      = 12,
  parameter int WORD_W     = 16,
  parameter int CONV_EDGES = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic             free_run,
  input  logic [RES_W-1:0] res_in,
  output logic             busy_o,
  output logic             frame_n_o,
  output logic             sdat_o,
  output logic             sclk_oe_o,
  output logic             hold_o,
  output logic             done_o
);
  import cst_pkg::*;

  localparam int LEAD = WORD_W - RES_W;
  localparam int EW   = $clog2(CONV_EDGES + 1);
  localparam logic [EW-1:0] FRAME_END = EW'(WORD_W + 1);
  localparam logic [EW-1:0] CONV_END  = EW'(CONV_EDGES);

  phase_e             phase;
  logic [EW-1:0]      edges;
  logic [EW-1:0]      edges_inc;
  logic [WORD_W-1:0]  word_q;

  assign edges_inc = edges + 1'b1;
  assign busy_o    = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      edges     <= '0;
      word_q    <= '0;
      frame_n_o <= 1'b1;
      sdat_o    <= 1'b0;
      sclk_oe_o <= 1'b0;
      hold_o    <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (frame_n_o) sclk_oe_o <= free_run;
      case (phase)
        PH_IDLE: if (start) begin
          phase  <= PH_SYNC;
          hold_o <= 1'b1;
          edges  <= '0;
          word_q <= {{LEAD{1'b0}}, res_in};
        end
        PH_SYNC: if (tick) begin
          phase     <= PH_WORD;
          edges     <= edges_inc;
          frame_n_o <= 1'b0;
          sclk_oe_o <= 1'b1;
          sdat_o    <= word_q[WORD_W-1];
          word_q    <= {word_q[WORD_W-2:0], 1'b0};
        end
        PH_WORD: if (tick) begin
          edges <= edges_inc;
          if (edges_inc == FRAME_END) begin
            phase     <= PH_TAIL;
            frame_n_o <= 1'b1;
            sdat_o    <= 1'b0;
            sclk_oe_o <= free_run;
          end else begin
            sdat_o <= word_q[WORD_W-1];
            word_q <= {word_q[WORD_W-2:0], 1'b0};
          end
        end
        PH_TAIL: if (tick) begin
          edges <= edges_inc;
          if (edges_inc == CONV_END) begin
            phase  <= PH_IDLE;
            hold_o <= 1'b0;
            done_o <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R7
  frame_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_n_o |-> hold_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!hold_o && frame_n_o));

  // R10
  restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && phase == PH_WORD) |=> hold_o);

endmodule

// File: rtl/conv_serial_tx.sv
module conv_serial_tx #(
  parameter int RES_W       = 12,
  parameter int WORD_W      = 16,
  parameter int CONV_EDGES  = 19,
  parameter int CLK_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnv_start_in,
  input  logic             free_run,
  input  logic [RES_W-1:0] res_in,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  output logic             frame_n_o,
  output logic             sdat_o,
  output logic             hold_o,
  output logic             done_o
);

  logic start_rise;
  logic tick;
  logic busy;
  logic park;

  // gated mode: divider sits parked until a start is accepted
  assign park = ~free_run & ~busy & ~start_rise;

  cst_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (cnv_start_in),
    .rise_o   (start_rise)
  );

  cst_sclk_gen #(.DIV(CLK_DIV)) u_sclk (
    .clk    (clk),
    .rst    (rst),
    .park   (park),
    .tick_o (tick),
    .sclk_o (sclk_o)
  );

  cst_frame_ctrl #(
    .RES_W      (RES_W),
    .WORD_W     (WORD_W),
    .CONV_EDGES (CONV_EDGES)
  ) u_frame (
    .clk       (clk),
    .rst       (rst),
    .start     (start_rise),
    .tick      (tick),
    .free_run  (free_run),
    .res_in    (res_in),
    .busy_o    (busy),
    .frame_n_o (frame_n_o),
    .sdat_o    (sdat_o),
    .sclk_oe_o (sclk_oe_o),
    .hold_o    (hold_o),
    .done_o    (done_o)
  );

  // R7
  frame_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(frame_n_o) |-> sclk_o);

  // R8
  clock_driven_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_n_o |-> sclk_oe_o);

endmodule

// File: tb/conv_serial_tx_test.sv
module conv_serial_tx_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cst = 1'b0;
  logic        fr  = 1'b0;
  logic [11:0] res = '0;
  logic sclk_o, sclk_oe_o, frame_n_o, sdat_o, hold_o, done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  conv_serial_tx uut (
    .clk          (clk),
    .rst          (rst),
    .cnv_start_in (cst),
    .free_run     (fr),
    .res_in       (res),
    .sclk_o       (sclk_o),
    .sclk_oe_o    (sclk_oe_o),
    .frame_n_o    (frame_n_o),
    .sdat_o       (sdat_o),
    .hold_o       (hold_o),
    .done_o       (done_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one conversion, observed at the pins and compared with the requirements
  task automatic run_conv(input logic [11:0] val, input bit late, input bit glitch);
    int   guard    = 0;
    int   rises    = 0;
    int   nb       = 0;
    int   hold_at  = -1;
    bit   oe_bad   = 0;
    bit   hold_dn  = 1;
    bit   frame_dn = 0;
    bit   rr;
    logic ps;
    logic [15:0] got = '0;
    res = val;
    if (fr) begin
      @(negedge clk); ps = sclk_o;
      do begin
        @(negedge clk); guard++;
        rr = sclk_o & ~ps; ps = sclk_o;
      end while (!rr && guard < 100);
      if (late) repeat (5) @(negedge clk);
      guard = 0;
    end
    cst = 1'b1;
    ps  = sclk_o;
    do begin
      @(negedge clk); guard++;
      if (sclk_o && !ps) rises++;
      if (!sclk_o && ps && !frame_n_o) begin got = {got[14:0], sdat_o}; nb++; end
      if (!frame_n_o && !sclk_oe_o) oe_bad = 1;
      if (!fr && frame_n_o && sclk_oe_o) oe_bad = 1;
      if (fr && !sclk_oe_o) oe_bad = 1;
      if (hold_o && hold_at < 0) hold_at = guard;
      if (glitch && guard == 20) cst = 1'b0;
      if (glitch && guard == 26) cst = 1'b1;
      if (done_o) begin hold_dn = hold_o; frame_dn = frame_n_o; end
      ps = sclk_o;
    end while (!done_o && guard < 2000);
    check("R9", "conversion finished", 32'(guard < 2000), 32'd1);
    check("R2", "hold latency", 32'(hold_at), 32'd3);
    check(late ? "R4" : (fr ? "R3" : "R5"), "rising edges", 32'(rises), late ? 32'd20 : 32'd19);
    check("R6", "bit count", 32'(nb), 32'd16);
    check("R6", "word", {16'h0, got}, {16'h0, 4'h0, val});
    check("R8", "clock enable", 32'(oe_bad), 32'd0);
    check("R9", "hold at done", 32'(hold_dn), 32'd0);
    check("R9", "frame at done", 32'(frame_dn), 32'd1);
    cst = 1'b0;
    @(negedge clk);
    check("R9", "done pulse width", 32'(done_o), 32'd0);
    check("R8", "idle clock enable", 32'(sclk_oe_o), 32'(fr));
    begin
      bit stray = 0;
      repeat (60) begin
        @(negedge clk);
        if (!frame_n_o || hold_o || done_o) stray = 1;
      end
      check(glitch ? "R10" : "R7", "quiet after done", 32'(stray), 32'd0);
    end
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "frame", 32'(frame_n_o), 32'd1);
    check("R1", "data", 32'(sdat_o), 32'd0);
    check("R1", "hold", 32'(hold_o), 32'd0);
    check("R1", "done", 32'(done_o), 32'd0);
    check("R1", "clock enable", 32'(sclk_oe_o), 32'd0);
    check("R1", "clock", 32'(sclk_o), 32'd0);
  endtask

  task automatic t_gated;
    bit moved = 0;
    fr = 1'b0;
    repeat (20) begin @(negedge clk); if (sclk_o) moved = 1; end
    check("R5", "parked clock", 32'(moved), 32'd0);
    run_conv(12'hA5C, 0, 0);
    run_conv(12'h800, 0, 0);
    run_conv(12'h7FF, 0, 0);
  endtask

  task automatic t_cont;
    fr = 1'b1;
    repeat (10) @(negedge clk);
    run_conv(12'h123, 0, 0);
    run_conv(12'hFFF, 1, 0);
    run_conv(12'h001, 1, 0);
  endtask

  task automatic t_restart;
    run_conv(12'h000, 0, 1);
    fr = 1'b0;
    repeat (5) @(negedge clk);
    run_conv(12'h5A3, 0, 1);
  endtask

  task automatic t_period;
    int   hi = 0, per = 0, g = 0;
    logic ps;
    fr = 1'b1;
    @(negedge clk); ps = sclk_o;
    while (!(sclk_o && !ps) && g < 100) begin ps = sclk_o; @(negedge clk); g++; end
    do begin @(negedge clk); hi++; end while (sclk_o && hi < 100);
    per = hi;
    do begin ps = sclk_o; @(negedge clk); per++; end while (!(sclk_o && !ps) && per < 100);
    check("R11", "high time", 32'(hi), 32'd4);
    check("R11", "period", 32'(per), 32'd8);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_gated();
    t_cont();
    t_period();
    t_restart();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule